// File: doc/BRIEF.md
# Legacy System Control Port Block

This block sits on a byte-wide, ISA-style I/O port bus and answers a small, sparse set of 8-bit ports that control the system. One port carries a fast CPU reset request and the little-endian mode flag. Several ports return fixed identification and equipment codes. Others hold control state: an activity LED, a 4-bit system control field and the I/O map-type bit. Two ports send one-shot lock-toggle requests to an external NVRAM.

Writes are taken on the clock edge while the write strobe is high. Read data is combinational and valid in the same cycle as the read strobe. Any port that is not decoded reads as 0xFF and ignores writes. A synchronous reset clears all held state.

Top module: `sysport_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, all stored state is cleared. After that edge `cpu_reset_req`, `little_endian`, `led_on`, `io_map_sparse` and `sys_ctl` are all 0.
- R2: A write to port 0x0092 sets `cpu_reset_req` from data bit 0 and `little_endian` from data bit 1, effective after the write edge. A read of 0x0092 returns 0x00.
- R3: Ports 0x0800, 0x0802 and 0x0803 read 0xEF, 0xAD and 0xE0. Writes to them change no output.
- R4: A write to port 0x0808 sets `led_on` to data bit 0.
- R5: A write of any value to 0x0810 raises `lock_pulse_a`, and a write to 0x0812 raises `lock_pulse_b`. The pulse lasts only the cycle in which the write strobe is accepted. Reads cause no pulse. A read of 0x0810 returns 0x39, and a read of 0x0812 returns 0xFF.
- R6: A write to port 0x081C stores data bits 3:0 in `sys_ctl`. A read of that port returns {4'b0000, sys_ctl}.
- R7: A write to port 0x0850 stores data bit 0 in `io_map_sparse`. A read of that port returns {7'b0, io_map_sparse}.
- R8: Reads return 0x3C at 0x080C, 0x00 at 0x0818 and 0x03 at 0x0823.
- R9: A read of any other port, 0x0814 included, returns 0xFF. A write to such a port changes no output and causes no pulse.
- R10: When `rd_en` is low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Port address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid with rd_en |
| cpu_reset_req | output | 1 | CPU reset request level |
| little_endian | output | 1 | Little-endian mode flag |
| led_on | output | 1 | Activity LED state |
| lock_pulse_a | output | 1 | NVRAM lock-toggle request 1 |
| lock_pulse_b | output | 1 | NVRAM lock-toggle request 2 |
| sys_ctl | output | 4 | System control value |
| io_map_sparse | output | 1 | I/O map type bit |

## Verification
The bench writes 0xA5 to the system control port. A design that stored all eight bits would then read back 0xA5 instead of 0x05. It writes to the read-only identification ports, to 0x0814 and to a far unmapped address, and checks that the held state is unchanged. A decoder that matched too loosely, or stored data for any address, would corrupt state there. It checks that each lock pulse lasts exactly one cycle and does not fire on a read, which catches a latched pulse or a decode that ignores the strobe. It also probes 0x0812 and 0x0814, which are writable or special but not readable. A mux that filled them with a fixed code would return something other than 0xFF.

// File: rtl/sysport_ctl.sv
`timescale 1ns/1ps
module sysport_ctl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              cpu_reset_req,
  output logic              little_endian,
  output logic              led_on,
  output logic              lock_pulse_a,
  output logic              lock_pulse_b,
  output logic [3:0]        sys_ctl,
  output logic              io_map_sparse
);
  localparam logic [ADDR_W-1:0] P_FAST  = ADDR_W'(16'h0092);
  localparam logic [ADDR_W-1:0] P_ID0   = ADDR_W'(16'h0800);
  localparam logic [ADDR_W-1:0] P_ID1   = ADDR_W'(16'h0802);
  localparam logic [ADDR_W-1:0] P_ID2   = ADDR_W'(16'h0803);
  localparam logic [ADDR_W-1:0] P_LED   = ADDR_W'(16'h0808);
  localparam logic [ADDR_W-1:0] P_EQUIP = ADDR_W'(16'h080C);
  localparam logic [ADDR_W-1:0] P_LOCKA = ADDR_W'(16'h0810);
  localparam logic [ADDR_W-1:0] P_LOCKB = ADDR_W'(16'h0812);
  localparam logic [ADDR_W-1:0] P_KEY   = ADDR_W'(16'h0818);
  localparam logic [ADDR_W-1:0] P_CTL   = ADDR_W'(16'h081C);
  localparam logic [ADDR_W-1:0] P_CACHE = ADDR_W'(16'h0823);
  localparam logic [ADDR_W-1:0] P_MAP   = ADDR_W'(16'h0850);

  logic wr_ok;
  assign wr_ok = wr_en && !rst;

  assign lock_pulse_a = wr_ok && (addr == P_LOCKA);
  assign lock_pulse_b = wr_ok && (addr == P_LOCKB);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_reset_req <= 1'b0;
      little_endian <= 1'b0;
      led_on        <= 1'b0;
      sys_ctl       <= 4'h0;
      io_map_sparse <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        P_FAST: begin
          cpu_reset_req <= wdata[0];
          little_endian <= wdata[1];
        end
        P_LED:   led_on        <= wdata[0];
        P_CTL:   sys_ctl       <= wdata[3:0];
        P_MAP:   io_map_sparse <= wdata[0];
        default: ;
      endcase
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (addr)
      P_FAST:  rd_mux = 8'h00;
      P_ID0:   rd_mux = 8'hEF;
      P_ID1:   rd_mux = 8'hAD;
      P_ID2:   rd_mux = 8'hE0;
      P_EQUIP: rd_mux = 8'h3C;
      P_LOCKA: rd_mux = 8'h39;
      P_KEY:   rd_mux = 8'h00;
      P_CTL:   rd_mux = {4'h0, sys_ctl};
      P_CACHE: rd_mux = 8'h03;
      P_MAP:   rd_mux = {7'h00, io_map_sparse};
      default: rd_mux = 8'hFF;
    endcase
  end

  assign rdata = rd_en ? rd_mux : 8'h00;
endmodule

// File: rtl/sysport_ctl_chk.sv
`timescale 1ns/1ps
module sysport_ctl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              cpu_reset_req,
  input logic              little_endian,
  input logic              led_on,
  input logic              lock_pulse_a,
  input logic              lock_pulse_b,
  input logic [3:0]        sys_ctl,
  input logic              io_map_sparse
);
  logic ctl_port;
  assign ctl_port = (addr == ADDR_W'(16'h0092)) || (addr == ADDR_W'(16'h0808)) ||
                    (addr == ADDR_W'(16'h081C)) || (addr == ADDR_W'(16'h0850));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> !cpu_reset_req && !little_endian && !led_on && sys_ctl == 4'h0 && !io_map_sparse);

  assert_fast_port_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(16'h0092)) |=>
      cpu_reset_req == $past(wdata[0]) && little_endian == $past(wdata[1]));

  assert_led_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(16'h0808)) |=> led_on == $past(wdata[0]));

  assert_pulse_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lock_pulse_a, lock_pulse_b}));

  assert_pulse_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> !lock_pulse_a && !lock_pulse_b);

  assert_ctl_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(16'h081C)) |=> sys_ctl == $past(wdata[3:0]));

  assert_map_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(16'h0850)) |=> io_map_sparse == $past(wdata[0]));

  assert_other_write_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ctl_port) |=>
      $stable({cpu_reset_req, little_endian, led_on, sys_ctl, io_map_sparse}));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rdata == 8'h00);
endmodule

bind sysport_ctl sysport_ctl_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/sysport_ctl_test.sv
`timescale 1ns/1ps
module sysport_ctl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        wr_en, rd_en;
  logic [7:0]  rdata;
  logic        cpu_reset_req, little_endian, led_on, lock_pulse_a, lock_pulse_b, io_map_sparse;
  logic [3:0]  sys_ctl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sysport_ctl uut (.*);

  // fields: {req[3:0], is_write, addr[15:0], data[7:0], expect[7:0]}
  // for writes, expect = {cpu_reset_req, little_endian, led_on, io_map_sparse, sys_ctl}
  localparam int NV = 26;
  localparam logic [36:0] VEC [NV] = '{
    {4'd2,  1'b1, 16'h0092, 8'h03, 8'hC0},  // R2
    {4'd2,  1'b0, 16'h0092, 8'h00, 8'h00},  // R2
    {4'd4,  1'b1, 16'h0808, 8'hFF, 8'hE0},  // R4
    {4'd6,  1'b1, 16'h081C, 8'hA5, 8'hE5},  // R6
    {4'd6,  1'b0, 16'h081C, 8'h00, 8'h05},  // R6
    {4'd7,  1'b1, 16'h0850, 8'h03, 8'hF5},  // R7
    {4'd7,  1'b0, 16'h0850, 8'h00, 8'h01},  // R7
    {4'd3,  1'b1, 16'h0800, 8'h00, 8'hF5},  // R3
    {4'd3,  1'b1, 16'h0803, 8'hFF, 8'hF5},  // R3
    {4'd9,  1'b1, 16'h1234, 8'hFF, 8'hF5},  // R9
    {4'd3,  1'b0, 16'h0800, 8'h00, 8'hEF},  // R3
    {4'd3,  1'b0, 16'h0802, 8'h00, 8'hAD},  // R3
    {4'd3,  1'b0, 16'h0803, 8'h00, 8'hE0},  // R3
    {4'd8,  1'b0, 16'h080C, 8'h00, 8'h3C},  // R8
    {4'd5,  1'b0, 16'h0810, 8'h00, 8'h39},  // R5
    {4'd8,  1'b0, 16'h0818, 8'h00, 8'h00},  // R8
    {4'd8,  1'b0, 16'h0823, 8'h00, 8'h03},  // R8
    {4'd5,  1'b0, 16'h0812, 8'h00, 8'hFF},  // R5
    {4'd9,  1'b0, 16'h0814, 8'h00, 8'hFF},  // R9
    {4'd9,  1'b0, 16'h0801, 8'h00, 8'hFF},  // R9
    {4'd2,  1'b1, 16'h0092, 8'h02, 8'h75},  // R2
    {4'd4,  1'b1, 16'h0808, 8'hFE, 8'h55},  // R4
    {4'd6,  1'b1, 16'h081C, 8'h0A, 8'h5A},  // R6
    {4'd7,  1'b1, 16'h0850, 8'h00, 8'h4A},  // R7
    {4'd7,  1'b0, 16'h0850, 8'h00, 8'h00},  // R7
    {4'd9,  1'b1, 16'h0814, 8'hFF, 8'h4A}   // R9
  };

  function automatic logic [7:0] status();
    return {cpu_reset_req, little_endian, led_on, io_map_sparse, sys_ctl};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #5;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #5 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    rst = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", status(), 8'h00);
    rst = 1'b0;

    // R10: idle read data with an address that would decode
    addr = 16'h0800;
    #2 check("R10 idle rdata", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][36:33], i);
      if (VEC[i][32]) begin
        do_write(VEC[i][31:16], VEC[i][15:8]);
        check(tag, status(), VEC[i][7:0]);
      end else begin
        do_read(VEC[i][31:16], rv);
        check(tag, rv, VEC[i][7:0]);
      end
    end

    // R5: one-cycle lock pulse on write to 0x0810
    @(negedge clk);
    addr = 16'h0810; wdata = 8'h00; wr_en = 1'b1;
    #5 check("R5 pulse a during write", {6'h0, lock_pulse_b, lock_pulse_a}, 8'h01);
    @(negedge clk);
    wr_en = 1'b0;
    #5 check("R5 pulse a after write", {6'h0, lock_pulse_b, lock_pulse_a}, 8'h00);

    // R5: lock pulse on write to 0x0812
    @(negedge clk);
    addr = 16'h0812; wdata = 8'h5A; wr_en = 1'b1;
    #5 check("R5 pulse b during write", {6'h0, lock_pulse_b, lock_pulse_a}, 8'h02);
    @(negedge clk);
    wr_en = 1'b0;
    check("R5 lock write leaves state", status(), 8'h4A);

    // R5: a read of the lock ports makes no pulse
    @(negedge clk);
    addr = 16'h0810; rd_en = 1'b1;
    #5 check("R5 no pulse on read", {6'h0, lock_pulse_b, lock_pulse_a}, 8'h00);
    @(negedge clk);
    rd_en = 1'b0;

    // R9: an unmapped write makes no pulse
    @(negedge clk);
    addr = 16'h0811; wdata = 8'hFF; wr_en = 1'b1;
    #5 check("R9 no pulse unmapped", {6'h0, lock_pulse_b, lock_pulse_a}, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;

    // R1: set everything, then reset
    do_write(16'h0092, 8'h03);
    do_write(16'h0808, 8'h01);
    do_write(16'h081C, 8'h0F);
    do_write(16'h0850, 8'h01);
    check("R1 preload", status(), 8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears", status(), 8'h00);
    do_read(16'h081C, rv);
    check("R1 R6 ctl after reset", rv, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule